// File: doc/BRIEF.md
# Triggered Latency-Window Sample Extractor

The block keeps a running history of multichannel ADC samples in a circular on-chip store. On every clock it writes one sample per channel at the current write position and never pauses. A trigger strobe marks an instant of interest. The block then looks back a programmed number of clocks from that instant, reads a programmed number of consecutive samples for every channel, and sends them out as one framed event.

The trigger line is shared with a short serial field. In the six clocks after the strobe, the same line carries a trigger-type code. Each accepted trigger is given a running event number and the value of a free-running clock-tick timestamp. The trigger waits in a small pending queue until the output is free. The queue depth drives a choke output so that the trigger source can hold back. A trigger that cannot be served, or a request for data that is invalid or already overwritten, sets a sticky error flag.

Top module: `trig_window_extractor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, ev_valid, ev_last and error are 0, and choke is 0 whenever cfg_hiwater is non-zero.
- R2: The second word of every frame is the 32-bit timestamp of the strobe cycle, counted in clocks from the last reset (the first cycle after reset has timestamp 0).
- R3: The data words follow the timestamp word in channel-major order: all samples of channel 0, then all samples of channel 1, and so on. Channel c, sample k (k from 0) is the value written at timestamp T - latency + k, zero-extended into the low bits. ev_last is high only on the final word.
- R4: A frame carries exactly 2 + NCH x W words, where W is the window length sampled at the strobe. Any W from 1 to MAXWIN is valid.
- R5: A strobe is trig_in high while no type field is being received. The next 6 cycles carry the type code MSB first, and highs on trig_in during those cycles start no trigger.
- R6: The header word (the first word) holds the event number in bits 31:6 and the type code in bits 5:0. Event numbers start at 0 after reset and increase by one for each trigger placed in the queue. Rejected triggers take no number.
- R7: A strobe is rejected, producing no frame and setting error, if any of these holds: W is 0, W exceeds MAXWIN, latency is below W, latency is at least DEPTH, or latency exceeds the current timestamp before DEPTH samples have been written.
- R8: A trigger that completes its type field while QDEPTH events are pending is dropped and sets error.
- R9: An event is sent only if age + 2 + (NCH-1) x W < DEPTH. Here age is the timestamp when the event leaves the queue minus its window start. Otherwise the event is discarded and error is set.
- R10: choke equals (number of pending events >= cfg_hiwater). The pending count rises in the cycle after the last type bit and falls in the cycle after the event is taken by an idle output.
- R11: error stays set until reset.
- R12: With an idle output and an empty queue, the header word appears 8 cycles after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset; clears timestamp, event number, queue and error |
| smp_in | input | NCH*SW | One sample per channel, channel c at bits c*SW +: SW |
| trig_in | input | 1 | Trigger strobe followed by the serial type code |
| cfg_lat | input | log2(DEPTH)+1 | Look-back distance in clocks |
| cfg_win | input | log2(MAXWIN)+1 | Samples per channel per event |
| cfg_hiwater | input | log2(QDEPTH)+1 | Pending-queue level at which choke is raised |
| ev_valid | output | 1 | Output word valid |
| ev_data | output | OW | Header, timestamp or sample word |
| ev_last | output | 1 | Final word of a frame |
| choke | output | 1 | Pending queue at or above the high-water mark |
| error | output | 1 | Sticky fault flag |

## Verification
Errors in the read address or the channel counter show up at once as sample words that do not match the pattern the bench writes, in the frame that follows the trigger. An off-by-one in the look-back arithmetic shifts every data word by one timestamp. An error in the pending count shows up in the cycle after a type field ends, as choke toggling at the wrong time, or as a missing or extra frame. Errors in the age or acceptance limits are exposed by triggers placed one step either side of each limit: they produce a frame where none is due, or a raised error flag where none is due.

// File: rtl/trig_window_extractor.sv
module trig_window_extractor #(
  parameter int NCH    = 4,
  parameter int SW     = 14,
  parameter int DEPTH  = 1024,
  parameter int MAXWIN = 256,
  parameter int QDEPTH = 4,
  parameter int TYPEW  = 6,
  parameter int OW     = 32,
  localparam int AW  = $clog2(DEPTH),
  localparam int LW  = AW + 1,
  localparam int WW  = $clog2(MAXWIN) + 1,
  localparam int QCW = $clog2(QDEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic              trig_in,
  input  logic [LW-1:0]     cfg_lat,
  input  logic [WW-1:0]     cfg_win,
  input  logic [QCW-1:0]    cfg_hiwater,
  output logic              ev_valid,
  output logic [OW-1:0]     ev_data,
  output logic              ev_last,
  output logic              choke,
  output logic              error
);
  localparam int QAW = $clog2(QDEPTH);
  localparam int CW  = $clog2(NCH);
  localparam int NW  = OW - TYPEW;
  localparam int RXW = $clog2(TYPEW + 1);
  localparam logic [31:0] DEPTH_U  = DEPTH;
  localparam logic [31:0] MAXWIN_U = MAXWIN;
  localparam logic [33:0] DEPTH_W  = DEPTH;
  localparam logic [33:0] NCH_M1   = NCH - 1;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_TS, S_SMP} st_t;

  logic [31:0]       ts;
  logic              primed;
  logic [NCH*SW-1:0] mem [DEPTH];
  logic [NCH*SW-1:0] rd_q;
  logic [AW-1:0]     rd_addr;

  always_ff @(posedge clk) begin
    mem[ts[AW-1:0]] <= smp_in;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts     <= '0;
      primed <= 1'b0;
    end else begin
      ts     <= ts + 32'd1;
      primed <= primed | (ts == DEPTH_U - 32'd1);
    end
  end

  logic [RXW-1:0]   rx_cnt;
  logic [TYPEW-1:0] rx_type;
  logic             rx_ok;
  logic [31:0]      rx_ts, rx_start;
  logic [WW-1:0]    rx_win;
  logic             strobe, win_ok, lat_ok, last_bit;
  logic [TYPEW-1:0] new_type;

  assign strobe   = trig_in && (rx_cnt == '0);
  assign win_ok   = (cfg_win != '0) && (32'(cfg_win) <= MAXWIN_U);
  assign lat_ok   = (32'(cfg_lat) >= 32'(cfg_win)) && (32'(cfg_lat) < DEPTH_U)
                    && (primed || (32'(cfg_lat) <= ts));
  assign last_bit = (rx_cnt == RXW'(1));
  assign new_type = {rx_type[TYPEW-2:0], trig_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt <= '0;
      rx_ok  <= 1'b0;
    end else if (strobe) begin
      rx_cnt   <= RXW'(TYPEW);
      rx_ok    <= win_ok && lat_ok;
      rx_ts    <= ts;
      rx_start <= ts - 32'(cfg_lat);
      rx_win   <= cfg_win;
    end else if (rx_cnt != '0) begin
      rx_cnt  <= rx_cnt - RXW'(1);
      rx_type <= new_type;
    end
  end

  logic [31:0]      q_start [QDEPTH];
  logic [31:0]      q_ts    [QDEPTH];
  logic [TYPEW-1:0] q_type  [QDEPTH];
  logic [NW-1:0]    q_num   [QDEPTH];
  logic [WW-1:0]    q_win   [QDEPTH];
  logic [QAW-1:0]   q_wp, q_rp;
  logic [QCW-1:0]   q_cnt;
  logic [NW-1:0]    ev_num;
  logic             q_full, push, ovf, pop, fresh;
  logic [33:0]      need;

  assign q_full = (q_cnt == QCW'(QDEPTH));
  assign push   = last_bit && rx_ok && !q_full;
  assign ovf    = last_bit && rx_ok && q_full;
  assign need   = 34'(ts - q_start[q_rp]) + 34'd2 + NCH_M1 * 34'(q_win[q_rp]);
  assign fresh  = need < DEPTH_W;

  st_t              st;
  logic [31:0]      c_start, c_ts;
  logic [TYPEW-1:0] c_type;
  logic [NW-1:0]    c_num;
  logic [WW-1:0]    c_win;
  logic [WW-1:0]    k;
  logic [CW-1:0]    ch;
  logic             k_end;

  assign pop   = (st == S_IDLE) && (q_cnt != '0);
  assign k_end = (k == c_win - WW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      q_wp   <= '0;
      q_rp   <= '0;
      q_cnt  <= '0;
      ev_num <= '0;
      error  <= 1'b0;
      k      <= '0;
      ch     <= '0;
    end else begin
      if (push) begin
        q_start[q_wp] <= rx_start;
        q_ts[q_wp]    <= rx_ts;
        q_type[q_wp]  <= new_type;
        q_num[q_wp]   <= ev_num;
        q_win[q_wp]   <= rx_win;
        q_wp          <= q_wp + QAW'(1);
        ev_num        <= ev_num + NW'(1);
      end
      if (pop) q_rp <= q_rp + QAW'(1);
      q_cnt <= q_cnt + QCW'(push) - QCW'(pop);
      error <= error | (strobe && !(win_ok && lat_ok)) | ovf | (pop && !fresh);
      case (st)
        S_IDLE: if (pop && fresh) begin
          c_start <= q_start[q_rp];
          c_ts    <= q_ts[q_rp];
          c_type  <= q_type[q_rp];
          c_num   <= q_num[q_rp];
          c_win   <= q_win[q_rp];
          k       <= '0;
          ch      <= '0;
          st      <= S_HDR;
        end
        S_HDR: st <= S_TS;
        S_TS:  st <= S_SMP;
        default: begin
          if (k_end) begin
            k <= '0;
            if (ch == CW'(NCH - 1)) st <= S_IDLE;
            else ch <= ch + CW'(1);
          end else begin
            k <= k + WW'(1);
          end
        end
      endcase
    end
  end

  assign rd_addr = c_start[AW-1:0] + ((st == S_SMP && !k_end) ? AW'(k) + AW'(1) : '0);

  logic [SW-1:0] cur_smp;
  assign cur_smp = rd_q[ch*SW +: SW];

  always_comb begin
    case (st)
      S_HDR:   ev_data = {c_num, c_type};
      S_TS:    ev_data = OW'(c_ts);
      S_SMP:   ev_data = OW'(cur_smp);
      default: ev_data = '0;
    endcase
  end

  assign ev_valid = (st != S_IDLE);
  assign ev_last  = (st == S_SMP) && (ch == CW'(NCH - 1)) && k_end;
  assign choke    = (q_cnt >= cfg_hiwater);
endmodule

module trig_window_extractor_chk #(
  parameter int QDEPTH = 4,
  localparam int QCW = $clog2(QDEPTH) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           ev_valid,
  input logic           ev_last,
  input logic           error,
  input logic [QCW-1:0] q_cnt
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !ev_valid && !error);
  // R3
  last_in_frame_chk: assert property (@(posedge clk) disable iff (rst) ev_last |-> ev_valid);
  // R3
  gap_after_last_chk: assert property (@(posedge clk) disable iff (rst) ev_last |=> !ev_valid);
  // R2
  frame_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_valid) |=> ev_valid && !ev_last);
  // R11
  error_sticky_chk: assert property (@(posedge clk) disable iff (rst) error |=> error);
  // R8
  queue_bound_chk: assert property (@(posedge clk) disable iff (rst) q_cnt <= QCW'(QDEPTH));
endmodule

bind trig_window_extractor trig_window_extractor_chk #(.QDEPTH(QDEPTH)) chk_i (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_last(ev_last),
  .error(error), .q_cnt(q_cnt)
);

// File: tb/trig_window_extractor_tb.sv
module trig_window_extractor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, SW = 8, DEPTH = 256, MAXWIN = 16, QDEPTH = 4;
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{ '{20, 8, 'h2A}, '{16, 16, 'h01}, '{9, 1, 'h3F},
                                  '{100, 5, 'h00}, '{45, 12, 'h15}, '{30, 3, 'h22} };

  logic clk = 1'b0;
  logic rst, trig_in, ev_valid, ev_last, choke, error;
  logic [NCH*SW-1:0] smp_in;
  logic [8:0]  cfg_lat;
  logic [4:0]  cfg_win;
  logic [2:0]  cfg_hiwater;
  logic [31:0] ev_data;

  trig_window_extractor #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .MAXWIN(MAXWIN), .QDEPTH(QDEPTH)) dut_i (
    .clk(clk), .rst(rst), .smp_in(smp_in), .trig_in(trig_in), .cfg_lat(cfg_lat),
    .cfg_win(cfg_win), .cfg_hiwater(cfg_hiwater), .ev_valid(ev_valid), .ev_data(ev_data),
    .ev_last(ev_last), .choke(choke), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, ts_m = 0, ncap = 0, nlast = 0;
  logic done = 1'b0, choke_seen = 1'b0;
  logic [31:0] cap_d [1024];
  int          cap_t [1024];
  logic        cap_l [1024];
  logic        choke_log [4096];

  function automatic logic [SW-1:0] pat(int i, int c);
    return SW'(i * 5 + c * 37 + 3);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ts_m = rst ? 0 : ts_m + 1;
    for (int c = 0; c < NCH; c++) smp_in[c*SW +: SW] = pat(ts_m, c);
    if (ev_valid && ncap < 1024) begin
      cap_d[ncap] = ev_data; cap_t[ncap] = ts_m; cap_l[ncap] = ev_last; ncap++;
    end
    if (ev_valid && ev_last) nlast++;
    if (choke) choke_seen = 1'b1;
    choke_log[ts_m % 4096] = choke;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clear_cap();
    ncap = 0; nlast = 0; choke_seen = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; trig_in = 1'b0;
    step(); step();
    rst = 1'b0;
    clear_cap();
  endtask

  task automatic prime();
    do_reset();
    wait_n(300);
  endtask

  task automatic send(int lat, int w, logic [5:0] ty, output int t);
    cfg_lat = 9'(lat); cfg_win = 5'(w);
    step();
    trig_in = 1'b1; t = ts_m;
    for (int b = 5; b >= 0; b--) begin
      step(); trig_in = ty[b];
    end
    step(); trig_in = 1'b0;
  endtask

  task automatic check_frame(int num, logic [5:0] ty, int t, int lat, int w);
    logic [31:0] ba, be;
    int lasts;
    ba = '0; be = '0; lasts = 0;
    check("R4", "word count", 32'(ncap), 32'(2 + NCH * w));
    if (ncap >= 2) begin
      check("R6", "header number", {6'd0, cap_d[0][31:6]}, 32'(num));
      check("R5", "header type", {26'd0, cap_d[0][5:0]}, {26'd0, ty});
      check("R2", "timestamp word", cap_d[1], 32'(t));
      check("R12", "header cycle", 32'(cap_t[0]), 32'(t + 8));
    end
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < w; k++) begin
        int idx = 2 + c * w + k;
        logic [31:0] e = 32'(pat(t - lat + k, c));
        if (idx < ncap && cap_d[idx] !== e && ba == be) begin ba = cap_d[idx]; be = e ^ 32'h0; if (ba == be) ba = ~ba; end
      end
    check("R3", "sample words", ba, be);
    for (int i = 0; i < ncap; i++) if (cap_l[i]) lasts++;
    check("R3", "last markers", 32'(lasts), 32'd1);
    if (ncap > 0) check("R3", "last on final word", 32'(cap_l[ncap-1]), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    rst = 1'b1; trig_in = 1'b0; cfg_lat = 9'd20; cfg_win = 5'd4; cfg_hiwater = 3'd1;
    smp_in = '0;
    step();
    check("R1", "ev_valid in reset", 32'(ev_valid), 0);
    step();
    rst = 1'b0;
    step();
    check("R1", "ev_valid after reset", 32'(ev_valid), 0);
    check("R1", "choke after reset", 32'(choke), 0);
    check("R1", "error after reset", 32'(error), 0);

    // R7: latency beyond the samples written so far
    clear_cap();
    send(20, 4, 6'h05, t);
    wait_n(40);
    check("R7", "frame for unwritten data", 32'(ncap), 0);
    check("R7", "error on unwritten data", 32'(error), 1);
    wait_n(30);
    check("R11", "error held", 32'(error), 1);
    do_reset();
    step();
    check("R11", "error cleared by reset", 32'(error), 0);

    // table walk
    wait_n(300);
    cfg_hiwater = 3'd4;
    for (int j = 0; j < NV; j++) begin
      clear_cap();
      send(VEC[j][0], VEC[j][1], 6'(VEC[j][2]), t);
      wait_n(50);
      check_frame(j, 6'(VEC[j][2]), t, VEC[j][0], VEC[j][1]);
    end
    check("R7", "no error for valid triggers", 32'(error), 0);

    // R10 choke timing with high-water 1
    cfg_hiwater = 3'd1;
    clear_cap();
    send(20, 4, 6'h0C, t);
    check("R10", "choke before push", 32'(choke_log[(t + 6) % 4096]), 0);
    check("R10", "choke with one pending", 32'(choke_log[(t + 7) % 4096]), 1);
    step();
    check("R10", "choke after pop", 32'(choke), 0);
    wait_n(40);
    check_frame(NV, 6'h0C, t, 20, 4);
    cfg_hiwater = 3'd0;
    step();
    check("R10", "choke at high-water 0", 32'(choke), 1);
    cfg_hiwater = 3'd4;

    // R9 age limit boundaries
    clear_cap();
    send(238, 8, 6'h2D, t);
    wait_n(50);
    check_frame(NV + 1, 6'h2D, t, 238, 8);
    check("R9", "no error at age limit", 32'(error), 0);
    clear_cap();
    send(239, 8, 6'h2E, t);
    wait_n(50);
    check("R9", "frame past age limit", 32'(ncap), 0);
    check("R9", "error past age limit", 32'(error), 1);

    // R7 latency below window, then numbering restarts without the rejected one
    prime();
    send(7, 8, 6'h01, t);
    wait_n(30);
    check("R7", "frame for latency below window", 32'(ncap), 0);
    check("R7", "error for latency below window", 32'(error), 1);
    clear_cap();
    send(20, 8, 6'h11, t);
    wait_n(50);
    check_frame(0, 6'h11, t, 20, 8);

    prime();
    send(256, 8, 6'h01, t);
    wait_n(30);
    check("R7", "frame for latency at depth", 32'(ncap), 0);
    check("R7", "error for latency at depth", 32'(error), 1);

    prime();
    send(20, 0, 6'h01, t);
    wait_n(30);
    check("R7", "error for zero window", 32'(error), 1);
    check("R7", "frame for zero window", 32'(ncap), 0);

    prime();
    send(40, 17, 6'h01, t);
    wait_n(60);
    check("R7", "error for window above max", 32'(error), 1);
    check("R7", "frame for window above max", 32'(ncap), 0);

    // R8 queue overflow, R10 choke at high-water equal to depth
    prime();
    cfg_hiwater = 3'd4;
    clear_cap();
    for (int j = 0; j < 8; j++) send(20, 16, 6'(j), t);
    wait_n(300);
    check("R8", "error on overflow", 32'(error), 1);
    check("R8", "frames at most 7", 32'(nlast <= 7), 1);
    check("R8", "frames at least queue depth", 32'(nlast >= QDEPTH), 1);
    check("R10", "choke raised with full queue", 32'(choke_seen), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule